// File: doc/BRIEF.md
# Register-Mapped GPIO Port with Keyed Commit Gate

This block is an eight-bit general purpose I/O port that sits behind a plain memory-mapped register interface covering a 4 KB window. Software sets each pin's direction, drives output pins through a data register, and reads input pins through the same register. Reads and writes of the data register carry a per-bit mask in address bits [9:2], so one bus access can touch any subset of pins without a read-modify-write sequence.

Every input passes through a two-flop synchroniser. It then feeds a per-bit event detector that can be set to level, rising-edge, falling-edge or both-edge mode. Events are held in a sticky raw status. The status is cleared by writing ones to a clear register, and after an enable mask it drives a single interrupt line. Writes to the alternate-function selection are filtered by a commit mask. That mask can only be changed after a magic key has opened the lock. The port also keeps eight bytes of pad settings (drive strength, pulls, open drain, slew, digital enable), which are storage only, and a read-only block of twelve identification bytes.

Top module: `gpio_port`

## Requirements
- R1: A read at any byte offset below 0x400 returns the data register ANDed with the mask taken from address bits [9:2], in bits [7:0]; bits [31:8] read 0.
- R2: A write at any offset below 0x400 changes only the data bits that are 1 both in the address mask (bits [9:2]) and in the direction register (offset 0x400, 1 = output); all other data bits keep their value.
- R3: Each pin output equals its data bit when its direction bit is 1 and is 1 when its direction bit is 0; after reset all direction bits are 0, so all pin outputs are 1.
- R4: A data bit whose direction is input takes the value of its pin after the two-flop synchroniser, so a pin change is readable at offset 0x3FC from the third rising edge after it; data bits set to output are not affected by pins.
- R5: The configuration bytes for level select (0x404), both-edge (0x408), polarity (0x40C) and enable mask (0x410) read back as written. Raw status reads at 0x414, masked status reads at 0x418 as raw AND mask, and the interrupt output is 1 exactly when the masked status is nonzero.
- R6: With level select bit 0, a status bit sets on any change of its synchronised pin when the both-edge bit is 1. When the both-edge bit is 0, it sets on a rising change if the polarity bit is 1 and on a falling change if it is 0.
- R7: With level select bit 1, a status bit sets on every cycle in which the synchronised pin equals its polarity bit, so a clear has no lasting effect while that condition holds.
- R8: Writing at 0x41C clears each raw status bit whose write-data bit is 1; a new event in the same cycle wins over the clear.
- R9: Writing 0x0ACCE551 at 0x520 unlocks the commit register and writing any other value locks it; reading 0x520 returns 1 when locked and 0 when unlocked; reset leaves it locked.
- R10: A write at 0x524 changes the commit mask only while unlocked; the commit mask resets to 0xFF and reads back at 0x524.
- R11: A write at 0x420 updates only the alternate-function bits whose commit mask bit is 1; the register reads back at 0x420 and resets to 0.
- R12: The eight pad setting bytes at 0x500, 0x504, … 0x51C are independent read/write storage that reset to 0.
- R13: Word reads from 0xFD0 to 0xFFC return, in address order, the bytes 00 00 00 00 61 00 18 01 0D F0 05 B1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte offset of the access within the window |
| bus_we | input | 1 | Write strobe, one write per cycle while high |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address, combinational |
| pin_in | input | 8 | Asynchronous pin inputs |
| pin_out | output | 8 | Pin drive values |
| irq | output | 1 | Interrupt, OR of the enabled status bits |

## Verification
On every cycle, assertions check the following: output-direction data bits change only on a data write, the commit mask changes only while unlocked, alternate-function bits change only where the commit mask allows, the lock changes only on a lock write, raw status bits appear only when the detector flags an event, and a clear removes every bit not re-hit in that cycle. Other behaviours can only be shown by the bench's scenarios: the address-bit read mask, the exact value written into the lock, commit and alternate-function registers, the synchroniser latency, each detector mode's response to real pin sequences, the enable mask on the interrupt line, and the identification bytes.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int unsigned GP_ADDR_W = 12;
  localparam int unsigned PAD_REGS  = 8;

  localparam logic [GP_ADDR_W-1:0] OFS_DATA_END = 12'h400;
  localparam logic [GP_ADDR_W-1:0] OFS_DIR      = 12'h400;
  localparam logic [GP_ADDR_W-1:0] OFS_LEVEL    = 12'h404;
  localparam logic [GP_ADDR_W-1:0] OFS_BOTH     = 12'h408;
  localparam logic [GP_ADDR_W-1:0] OFS_POL      = 12'h40C;
  localparam logic [GP_ADDR_W-1:0] OFS_ENA      = 12'h410;
  localparam logic [GP_ADDR_W-1:0] OFS_RAW      = 12'h414;
  localparam logic [GP_ADDR_W-1:0] OFS_MSK      = 12'h418;
  localparam logic [GP_ADDR_W-1:0] OFS_CLR      = 12'h41C;
  localparam logic [GP_ADDR_W-1:0] OFS_ALT      = 12'h420;
  localparam logic [GP_ADDR_W-1:0] OFS_PAD_BASE = 12'h500;
  localparam logic [GP_ADDR_W-1:0] OFS_KEYLOCK  = 12'h520;
  localparam logic [GP_ADDR_W-1:0] OFS_COMMIT   = 12'h524;
  localparam logic [GP_ADDR_W-1:0] OFS_IDENT    = 12'hFD0;

  localparam logic [31:0] OPEN_KEY = 32'h0ACC_E551;

  // Identification byte by word index counted from OFS_IDENT.
  function automatic logic [7:0] ident_byte(input logic [3:0] idx);
    case (idx)
      4'd4:    return 8'h61;
      4'd6:    return 8'h18;
      4'd7:    return 8'h01;
      4'd8:    return 8'h0D;
      4'd9:    return 8'hF0;
      4'd10:   return 8'h05;
      4'd11:   return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

  // One bit of the event detector: level or edge, with polarity.
  function automatic logic pin_event(input logic lvl, input logic both,
                                     input logic pol, input logic now,
                                     input logic was);
    if (lvl)       return now == pol;
    else if (both) return now ^ was;
    else if (pol)  return now & ~was;
    else           return ~now & was;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] synced,
  output logic [W-1:0] synced_prev
);

  localparam int unsigned DEPTH = STAGES + 1;

  logic [W-1:0] chain_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= '0;
    else        chain_q[0] <= pin_in;
  end

  for (genvar s = 1; s < DEPTH; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[s] <= '0;
      else        chain_q[s] <= chain_q[s-1];
    end
  end

  assign synced      = chain_q[STAGES-1];
  assign synced_prev = chain_q[STAGES];

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_sel,
  input  logic [W-1:0] both_sel,
  input  logic [W-1:0] pol_sel,
  input  logic [W-1:0] ena,
  input  logic [W-1:0] now_val,
  input  logic [W-1:0] was_val,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] ev_hit,
  output logic [W-1:0] raw_q,
  output logic [W-1:0] masked,
  output logic         irq
);

  logic [W-1:0] clr_eff;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign ev_hit[i] = pin_event(lvl_sel[i], both_sel[i], pol_sel[i],
                                 now_val[i], was_val[i]);
  end

  assign clr_eff = clr_we ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= (raw_q & ~clr_eff) | ev_hit;
  end

  assign masked = raw_q & ena;
  assign irq    = |masked;

  // R6
  raw_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_q & ~$past(raw_q)) & ~$past(ev_hit)) == '0);

  // R8
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_we) |-> ((raw_q & $past(clr_bits) & ~$past(ev_hit)) == '0));

endmodule

// File: rtl/gpio_key_guard.sv
module gpio_key_guard #(
  parameter int unsigned W   = 8,
  parameter int unsigned DW  = 32,
  parameter logic [DW-1:0] KEY = 32'h0ACC_E551
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock_we,
  input  logic          commit_we,
  input  logic          alt_we,
  input  logic [DW-1:0] wdata,
  output logic          locked,
  output logic [W-1:0]  commit,
  output logic [W-1:0]  alt_sel
);

  logic key_match;
  assign key_match = (wdata == KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       locked <= 1'b1;
    else if (lock_we) locked <= ~key_match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   commit <= '1;
    else if (commit_we && !locked) commit <= wdata[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      alt_sel <= '0;
    else if (alt_we) alt_sel <= (alt_sel & ~commit) | (wdata[W-1:0] & commit);
  end

  // R10
  commit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(locked) |-> $stable(commit));

  // R11
  alt_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((alt_sel ^ $past(alt_sel)) & ~$past(commit)) == '0);

  // R9
  lock_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(lock_we) |-> $stable(locked));

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned DW          = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [GP_ADDR_W-1:0] bus_addr,
  input  logic                 bus_we,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  input  logic [W-1:0]         pin_in,
  output logic [W-1:0]         pin_out,
  output logic                 irq
);

  localparam int unsigned PAD_IDX_W = $clog2(PAD_REGS);

  // Decode
  logic sel_data, sel_dir, sel_lvl, sel_both, sel_pol, sel_ena;
  logic sel_raw, sel_msk, sel_clr, sel_alt, sel_lock, sel_commit;
  logic sel_pad, sel_id, aligned;
  logic [PAD_IDX_W-1:0] pad_idx;
  logic [3:0]           id_idx;
  logic [W-1:0]         addr_mask;

  assign aligned    = (bus_addr[1:0] == 2'b00);
  assign sel_data   = (bus_addr < OFS_DATA_END);
  assign sel_dir    = (bus_addr == OFS_DIR);
  assign sel_lvl    = (bus_addr == OFS_LEVEL);
  assign sel_both   = (bus_addr == OFS_BOTH);
  assign sel_pol    = (bus_addr == OFS_POL);
  assign sel_ena    = (bus_addr == OFS_ENA);
  assign sel_raw    = (bus_addr == OFS_RAW);
  assign sel_msk    = (bus_addr == OFS_MSK);
  assign sel_clr    = (bus_addr == OFS_CLR);
  assign sel_alt    = (bus_addr == OFS_ALT);
  assign sel_lock   = (bus_addr == OFS_KEYLOCK);
  assign sel_commit = (bus_addr == OFS_COMMIT);
  assign sel_pad    = aligned && (bus_addr[GP_ADDR_W-1:5] == OFS_PAD_BASE[GP_ADDR_W-1:5]);
  assign pad_idx    = bus_addr[2 +: PAD_IDX_W];
  assign sel_id     = aligned && (bus_addr >= OFS_IDENT);
  assign id_idx     = bus_addr[5:2] - OFS_IDENT[5:2];
  assign addr_mask  = bus_addr[2 +: W];

  // Registers
  logic [W-1:0] data_q, dir_q, lvl_q, both_q, pol_q, ena_q;
  logic [W-1:0] pad_q [PAD_REGS];
  logic [W-1:0] wdata_lo;
  assign wdata_lo = bus_wdata[W-1:0];

  // Synchroniser
  logic [W-1:0] synced, synced_prev;

  gpio_in_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_in      (pin_in),
    .synced      (synced),
    .synced_prev (synced_prev)
  );

  // Data register: masked write on output bits, sampling on input bits
  logic         data_wr;
  logic [W-1:0] wr_mask, data_d;

  assign data_wr = bus_we && sel_data;
  assign wr_mask = data_wr ? (addr_mask & dir_q) : '0;

  always_comb begin
    data_d = (data_q & dir_q & ~wr_mask) | (wdata_lo & wr_mask) | (synced & ~dir_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      lvl_q  <= '0;
      both_q <= '0;
      pol_q  <= '0;
      ena_q  <= '0;
    end else if (bus_we) begin
      if (sel_dir)  dir_q  <= wdata_lo;
      if (sel_lvl)  lvl_q  <= wdata_lo;
      if (sel_both) both_q <= wdata_lo;
      if (sel_pol)  pol_q  <= wdata_lo;
      if (sel_ena)  ena_q  <= wdata_lo;
    end
  end

  for (genvar k = 0; k < PAD_REGS; k++) begin : g_pad
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                              pad_q[k] <= '0;
      else if (bus_we && sel_pad && pad_idx == PAD_IDX_W'(k)) pad_q[k] <= wdata_lo;
    end
  end

  assign pin_out = (data_q & dir_q) | ~dir_q;

  // Interrupt detection
  logic [W-1:0] ev_hit, raw_q, masked;

  gpio_irq_detect #(.W(W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_sel  (lvl_q),
    .both_sel (both_q),
    .pol_sel  (pol_q),
    .ena      (ena_q),
    .now_val  (synced),
    .was_val  (synced_prev),
    .clr_we   (bus_we && sel_clr),
    .clr_bits (wdata_lo),
    .ev_hit   (ev_hit),
    .raw_q    (raw_q),
    .masked   (masked),
    .irq      (irq)
  );

  // Lock, commit and alternate function
  logic         locked;
  logic [W-1:0] commit, alt_sel;

  gpio_key_guard #(.W(W), .DW(DW), .KEY(DW'(OPEN_KEY))) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_we   (bus_we && sel_lock),
    .commit_we (bus_we && sel_commit),
    .alt_we    (bus_we && sel_alt),
    .wdata     (bus_wdata),
    .locked    (locked),
    .commit    (commit),
    .alt_sel   (alt_sel)
  );

  // Read mux
  logic [W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (sel_data)        rd_val = data_q & addr_mask;
    else if (sel_dir)    rd_val = dir_q;
    else if (sel_lvl)    rd_val = lvl_q;
    else if (sel_both)   rd_val = both_q;
    else if (sel_pol)    rd_val = pol_q;
    else if (sel_ena)    rd_val = ena_q;
    else if (sel_raw)    rd_val = raw_q;
    else if (sel_msk)    rd_val = masked;
    else if (sel_alt)    rd_val = alt_sel;
    else if (sel_lock)   rd_val = W'(locked);
    else if (sel_commit) rd_val = commit;
    else if (sel_pad)    rd_val = pad_q[pad_idx];
    else if (sel_id)     rd_val = W'(ident_byte(id_idx));
  end

  assign bus_rdata = DW'(rd_val);

  // R2
  out_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(data_wr) |-> (((data_q ^ $past(data_q)) & $past(dir_q)) == '0));

endmodule

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pin_in = '0;
  logic [7:0]  pin_out;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [7:0]  exp;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 30;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h400, 32'h0000_00F0, 8'h00, 8'd2},  // R2 dir upper nibble out
    '{1'b1, 12'h3FC, 32'h0000_00AB, 8'h00, 8'd2},  // R2 full mask write
    '{1'b0, 12'h3FC, 32'h0,         8'hA0, 8'd1},  // R1 read all bits
    '{1'b0, 12'h0C0, 32'h0,         8'h20, 8'd1},  // R1 mask 0x30
    '{1'b1, 12'h080, 32'h0000_0000, 8'h00, 8'd2},  // R2 clear bit5 only
    '{1'b0, 12'h3FC, 32'h0,         8'h80, 8'd2},  // R2
    '{1'b1, 12'h420, 32'h0000_005A, 8'h00, 8'd11}, // R11 full commit
    '{1'b0, 12'h420, 32'h0,         8'h5A, 8'd11},
    '{1'b1, 12'h524, 32'h0000_0000, 8'h00, 8'd10}, // R10 locked write
    '{1'b0, 12'h524, 32'h0,         8'hFF, 8'd10},
    '{1'b1, 12'h520, 32'h0ACC_E551, 8'h00, 8'd9},  // R9 unlock
    '{1'b0, 12'h520, 32'h0,         8'h00, 8'd9},
    '{1'b1, 12'h524, 32'h0000_000F, 8'h00, 8'd10}, // R10 unlocked write
    '{1'b0, 12'h524, 32'h0,         8'h0F, 8'd10},
    '{1'b1, 12'h520, 32'h0000_0001, 8'h00, 8'd9},  // R9 relock
    '{1'b0, 12'h520, 32'h0,         8'h01, 8'd9},
    '{1'b1, 12'h420, 32'h0000_00FF, 8'h00, 8'd11}, // R11 partial commit
    '{1'b0, 12'h420, 32'h0,         8'h5F, 8'd11},
    '{1'b1, 12'h524, 32'h0000_00FF, 8'h00, 8'd10}, // R10 locked again
    '{1'b0, 12'h524, 32'h0,         8'h0F, 8'd10},
    '{1'b1, 12'h508, 32'h0000_0033, 8'h00, 8'd12}, // R12 pad storage
    '{1'b0, 12'h508, 32'h0,         8'h33, 8'd12},
    '{1'b0, 12'h51C, 32'h0,         8'h00, 8'd12},
    '{1'b1, 12'h51C, 32'h0000_00C4, 8'h00, 8'd12},
    '{1'b0, 12'h51C, 32'h0,         8'hC4, 8'd12},
    '{1'b0, 12'h508, 32'h0,         8'h33, 8'd12},
    '{1'b1, 12'h410, 32'h0000_00C3, 8'h00, 8'd5},  // R5 config readback
    '{1'b0, 12'h410, 32'h0,         8'hC3, 8'd5},
    '{1'b1, 12'h408, 32'h0000_0066, 8'h00, 8'd5},
    '{1'b0, 12'h408, 32'h0,         8'h66, 8'd5}
  };

  localparam logic [7:0] ID_EXP [12] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h61, 8'h00,
                                         8'h18, 8'h01, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [11:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 check(bus_rdata, {24'h0, e}, tag);
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state
    rd_chk(12'h520, 8'h01, "R9 reset locked");
    rd_chk(12'h524, 8'hFF, "R10 reset commit");
    rd_chk(12'h420, 8'h00, "R11 reset alt");
    rd_chk(12'h400, 8'h00, "R3 reset dir");
    #1 check({24'h0, pin_out}, 32'hFF, "R3 reset pins float high");
    check({31'h0, irq}, 32'h0, "R5 reset irq");

    // Table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
      else rd_chk(VECS[i].addr, VECS[i].exp, $sformatf("R%0d vector %0d", VECS[i].req, i));
    end

    // R3: dir F0, data 80
    @(negedge clk); #1 check({24'h0, pin_out}, 32'h8F, "R3 pin drive mix");

    // R4: input sampling through synchroniser
    @(negedge clk); pin_in = 8'hFF;
    repeat (2) @(posedge clk);
    #1 bus_addr = 12'h3FC;
    #0 check(bus_rdata, 32'h80, "R4 not yet visible after two edges");
    settle();
    rd_chk(12'h3FC, 8'h8F, "R4 input bits follow pins, outputs kept");
    @(negedge clk); pin_in = 8'h00;
    settle();
    rd_chk(12'h3FC, 8'h80, "R4 input bits back low");

    // Interrupts: edge modes
    wr(12'h404, 32'h00);
    wr(12'h40C, 32'h01);
    wr(12'h408, 32'h02);
    wr(12'h410, 32'hFF);
    wr(12'h41C, 32'hFF);
    rd_chk(12'h414, 8'h00, "R8 clear all");
    @(negedge clk); pin_in = 8'h03;
    settle();
    rd_chk(12'h414, 8'h03, "R6 rising on bit0, both on bit1");
    #1 check({31'h0, irq}, 32'h1, "R5 irq on");
    rd_chk(12'h418, 8'h03, "R5 masked full");
    wr(12'h410, 32'h02);
    rd_chk(12'h418, 8'h02, "R5 masked partial");
    wr(12'h410, 32'h00);
    #1 check({31'h0, irq}, 32'h0, "R5 irq masked off");
    wr(12'h41C, 32'h03);
    rd_chk(12'h414, 8'h00, "R8 clear selected");
    @(negedge clk); pin_in = 8'h00;
    settle();
    rd_chk(12'h414, 8'h02, "R6 falling sets only both-edge bit");
    wr(12'h41C, 32'hFF);

    // Interrupts: level mode on bit2, active high
    wr(12'h404, 32'h04);
    wr(12'h40C, 32'h04);
    @(negedge clk); pin_in = 8'h04;
    settle();
    rd_chk(12'h414, 8'h04, "R7 level high sets");
    wr(12'h41C, 32'h04);
    rd_chk(12'h414, 8'h04, "R7 level re-sets over clear");
    @(negedge clk); pin_in = 8'h00;
    settle();
    wr(12'h41C, 32'h04);
    rd_chk(12'h414, 8'h00, "R7 clear sticks once level gone");

    // Identification bytes
    for (int j = 0; j < 12; j++)
      rd_chk(12'hFD0 + 12'(4 * j), ID_EXP[j], $sformatf("R13 id byte %0d", j));

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule